// File: doc/BRIEF.md
# Boot-Window Command Sequencer

This block sits on the write side of a flash controller's boot-buffer window. Each bus write that lands inside one of the two command ranges of the window is treated as a command word. The block turns those words into single-cycle requests for the rest of the controller: a warm reset of the controller, a one-page load into the first data buffer, and a three-location identification write into the boot buffer.

A page load takes two writes. The first write arms the block. The second write fires the load only when its value is zero, and it always disarms the block. The block owns the start-page register. Each load presents the register's current value to the load engine and then advances the register by a fixed step, wrapped to its low byte. Software can also write the register directly through a dedicated port. The load engine and the buffer memory are separate blocks.

Top module: `boot_cmd_seq`

## Requirements
- R1: A write is a command only when its word address lies in 0x0000..0x01FF or in 0x8000..0x800F. Writes at any other address cause no strobe and leave the armed state unchanged.
- R2: Command 0x00F0, written while not armed, gives `reset_req_o` high for exactly one cycle, in the cycle after the write, and clears `page_o` to 0x0000.
- R3: Command 0x00E0, written while not armed, arms the block and gives no strobe.
- R4: While the block is armed, the next in-window write disarms it whatever its value. A non-zero value then gives no strobe and leaves `page_o` unchanged, even when it is 0x00F0, 0x00E0 or 0x0090.
- R5: An in-window write of 0x0000 while armed gives `load_req_o` high for one cycle, in the cycle after the write. In that cycle `load_page_o` holds the value `page_o` had before the write.
- R6: After a load, `page_o` equals (previous value + 4) AND 0x00FF. For example, 0x1234 becomes 0x0038, and 0x00FE becomes 0x0002.
- R7: Command 0x0090, written while not armed, raises `id_wr_o` for the three cycles after the write, with `id_idx_o` = 0, 1, 2 in turn. `id_data_o` is {8'h00, `mfr_id_i`}, then {8'h00, `dev_id_i`}, then {8'h00, `wp_stat_i`}. Each value is captured on the cycle of the write.
- R8: Any other value written in-window while not armed gives no strobe and no state change.
- R9: `rst_ni` low disarms the block, clears `page_o` and `load_page_o` to 0, and holds every strobe low.
- R10: `pg_wr_i` loads `pg_data_i` into the start-page register at the next edge. In that same cycle it takes priority over the step of R6 and the clear of R2.
- R11: A 0x0090 command that arrives while an identification sequence still has a location other than 2 to emit is ignored. A command that arrives in the cycle that shows location 2 starts a new sequence right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | 16 | Word address of the write |
| wr_data_i | input | 16 | Write data / command word |
| pg_wr_i | input | 1 | Direct write of the start-page register |
| pg_data_i | input | 16 | Value for the direct page write |
| mfr_id_i | input | 8 | Manufacturer ID low byte |
| dev_id_i | input | 8 | Device ID low byte |
| wp_stat_i | input | 8 | Write-protect status low byte |
| reset_req_o | output | 1 | Warm reset request strobe |
| load_req_o | output | 1 | Page load request strobe |
| load_page_o | output | 16 | Page value for the current load |
| page_o | output | 16 | Current start-page register |
| id_wr_o | output | 1 | Identification location write strobe |
| id_idx_o | output | 2 | Boot-buffer location index 0..2 |
| id_data_o | output | 16 | Word written to that location |

## Verification
The bench builds the block with its default parameters: two windows at 0x0000..0x01FF and 0x8000..0x800F, a 16-bit page register that wraps in its low 8 bits, a step of 4, and three identification locations. With these values the tests can reach both edges of each window and the addresses just outside them, and a single load from 0x00FE reaches the page wrap. The identification sequence is short enough that the tests can place back-to-back commands both inside a running sequence and in the cycle where it ends.

// File: rtl/boot_seq_pkg.sv
`timescale 1ns/1ps
package boot_seq_pkg;
  localparam int CMD_W = 16;

  localparam logic [CMD_W-1:0] CMD_WARM_RST = 16'h00F0;
  localparam logic [CMD_W-1:0] CMD_ARM_LOAD = 16'h00E0;
  localparam logic [CMD_W-1:0] CMD_READ_ID  = 16'h0090;
  localparam logic [CMD_W-1:0] CMD_LOAD_GO  = 16'h0000;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_RESET,
    ACT_LOAD,
    ACT_ID
  } act_e;
endpackage

// File: rtl/boot_win_dec.sv
`timescale 1ns/1ps
module boot_win_dec #(
  parameter int ADDR_W  = 16,
  parameter int NUM_WIN = 2,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_LO = '0,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_HI = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic [NUM_WIN-1:0] hits;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [ADDR_W-1:0] LO  = WIN_LO[w*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] HI  = WIN_HI[w*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] SPAN = HI - LO;
    logic [ADDR_W-1:0] rel;
    // offset below LO wraps to a large value and fails the span test
    assign rel     = addr_i - LO;
    assign hits[w] = (rel <= SPAN);
  end

  assign hit_o = |hits;
endmodule

// File: rtl/boot_cmd_dec.sv
`timescale 1ns/1ps
module boot_cmd_dec
  import boot_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             hit_i,
  input  logic [CMD_W-1:0] data_i,
  output act_e             act_o,
  output logic             pend_o,
  output logic             reset_req_o,
  output logic             load_req_o
);
  logic pend_q, pend_d;
  logic rst_req_q, load_req_q;
  act_e act;

  always_comb begin
    act    = ACT_NONE;
    pend_d = pend_q;
    if (wr_en_i && hit_i) begin
      if (pend_q) begin
        pend_d = 1'b0;
        if (data_i == CMD_LOAD_GO) act = ACT_LOAD;
      end else begin
        unique case (data_i)
          CMD_WARM_RST: act    = ACT_RESET;
          CMD_ARM_LOAD: pend_d = 1'b1;
          CMD_READ_ID:  act    = ACT_ID;
          default:      ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      rst_req_q  <= 1'b0;
      load_req_q <= 1'b0;
    end else begin
      pend_q     <= pend_d;
      rst_req_q  <= (act == ACT_RESET);
      load_req_q <= (act == ACT_LOAD);
    end
  end

  assign act_o       = act;
  assign pend_o      = pend_q;
  assign reset_req_o = rst_req_q;
  assign load_req_o  = load_req_q;
endmodule

// File: rtl/boot_page_reg.sv
`timescale 1ns/1ps
module boot_page_reg
  import boot_seq_pkg::*;
#(
  parameter int PAGE_W      = 16,
  parameter int PAGE_WRAP_W = 8,
  parameter int PAGE_STEP   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  act_e              act_i,
  input  logic              pg_wr_i,
  input  logic [PAGE_W-1:0] pg_data_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [PAGE_W-1:0] load_page_o
);
  localparam int HI_W = PAGE_W - PAGE_WRAP_W;

  logic [PAGE_W-1:0] page_q, load_page_q, sum, page_step;

  assign sum       = page_q + PAGE_W'(PAGE_STEP);
  assign page_step = {{HI_W{1'b0}}, sum[PAGE_WRAP_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q      <= '0;
      load_page_q <= '0;
    end else begin
      if (pg_wr_i)                 page_q <= pg_data_i;
      else if (act_i == ACT_LOAD)  page_q <= page_step;
      else if (act_i == ACT_RESET) page_q <= '0;
      if (act_i == ACT_LOAD) load_page_q <= page_q;
    end
  end

  assign page_o      = page_q;
  assign load_page_o = load_page_q;
endmodule

// File: rtl/boot_id_seq.sv
`timescale 1ns/1ps
module boot_id_seq #(
  parameter int ID_W    = 8,
  parameter int ID_LOCS = 3,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(ID_LOCS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [ID_LOCS*ID_W-1:0] src_i,
  output logic                    id_wr_o,
  output logic [IDX_W-1:0]        id_idx_o,
  output logic [DATA_W-1:0]       id_data_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ID_LOCS - 1);

  logic                    active_q;
  logic [IDX_W-1:0]        idx_q;
  logic [ID_LOCS*ID_W-1:0] bytes_q;
  logic [ID_W-1:0]         sel;
  logic                    accept;

  // a new request is taken only when idle or on the final location
  assign accept = start_i && (!active_q || idx_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      bytes_q  <= '0;
    end else if (accept) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      bytes_q  <= src_i;
    end else if (active_q) begin
      if (idx_q == LAST) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < ID_LOCS; i++) begin
      if (idx_q == IDX_W'(i)) sel = bytes_q[i*ID_W +: ID_W];
    end
  end

  assign id_wr_o   = active_q;
  assign id_idx_o  = idx_q;
  assign id_data_o = {{(DATA_W-ID_W){1'b0}}, sel};
endmodule

// File: rtl/boot_cmd_seq.sv
`timescale 1ns/1ps
module boot_cmd_seq
  import boot_seq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_W      = 16,
  parameter int PAGE_WRAP_W = 8,
  parameter int PAGE_STEP   = 4,
  parameter int ID_W        = 8,
  parameter int ID_LOCS     = 3,
  parameter int NUM_WIN     = 2,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_LO = {16'h8000, 16'h0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_HI = {16'h800F, 16'h01FF},
  localparam int IDX_W      = $clog2(ID_LOCS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CMD_W-1:0]  wr_data_i,
  input  logic              pg_wr_i,
  input  logic [PAGE_W-1:0] pg_data_i,
  input  logic [ID_W-1:0]   mfr_id_i,
  input  logic [ID_W-1:0]   dev_id_i,
  input  logic [ID_W-1:0]   wp_stat_i,
  output logic              reset_req_o,
  output logic              load_req_o,
  output logic [PAGE_W-1:0] load_page_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              id_wr_o,
  output logic [IDX_W-1:0]  id_idx_o,
  output logic [CMD_W-1:0]  id_data_o
);
  logic win_hit;
  logic load_pend;
  act_e act;

  boot_win_dec #(
    .ADDR_W (ADDR_W),
    .NUM_WIN(NUM_WIN),
    .WIN_LO (WIN_LO),
    .WIN_HI (WIN_HI)
  ) u_win (
    .addr_i(wr_addr_i),
    .hit_o (win_hit)
  );

  boot_cmd_dec u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .hit_i      (win_hit),
    .data_i     (wr_data_i),
    .act_o      (act),
    .pend_o     (load_pend),
    .reset_req_o(reset_req_o),
    .load_req_o (load_req_o)
  );

  boot_page_reg #(
    .PAGE_W     (PAGE_W),
    .PAGE_WRAP_W(PAGE_WRAP_W),
    .PAGE_STEP  (PAGE_STEP)
  ) u_page (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .pg_wr_i    (pg_wr_i),
    .pg_data_i  (pg_data_i),
    .page_o     (page_o),
    .load_page_o(load_page_o)
  );

  boot_id_seq #(
    .ID_W   (ID_W),
    .ID_LOCS(ID_LOCS),
    .DATA_W (CMD_W)
  ) u_id (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (act == ACT_ID),
    .src_i    ({wp_stat_i, dev_id_i, mfr_id_i}),
    .id_wr_o  (id_wr_o),
    .id_idx_o (id_idx_o),
    .id_data_o(id_data_o)
  );
endmodule

// File: rtl/boot_cmd_seq_chk.sv
`timescale 1ns/1ps
module boot_cmd_seq_chk #(
  parameter int PAGE_W      = 16,
  parameter int PAGE_WRAP_W = 8,
  parameter int PAGE_STEP   = 4,
  parameter int IDX_W       = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [15:0]       wr_data_i,
  input logic              win_hit,
  input logic              load_pend,
  input logic              pg_wr_i,
  input logic              reset_req_o,
  input logic              load_req_o,
  input logic [PAGE_W-1:0] load_page_o,
  input logic [PAGE_W-1:0] page_o,
  input logic              id_wr_o,
  input logic [IDX_W-1:0]  id_idx_o
);
  logic [PAGE_W-1:0] sum, step_exp;
  assign sum      = load_page_o + PAGE_W'(PAGE_STEP);
  assign step_exp = {{(PAGE_W-PAGE_WRAP_W){1'b0}}, sum[PAGE_WRAP_W-1:0]};

  AST_OUT_OF_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !win_hit |=> $stable(load_pend) && !reset_req_o && !load_req_o); // R1
  AST_RST_CLEARS_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o && !$past(pg_wr_i) |-> page_o == '0); // R2
  AST_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && win_hit && !load_pend && wr_data_i == 16'h00E0
    |=> load_pend && !reset_req_o && !load_req_o); // R3
  AST_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && win_hit && load_pend |=> !load_pend); // R4
  AST_LOAD_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && win_hit && load_pend && wr_data_i == 16'h0000 |=> load_req_o); // R5
  AST_PAGE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_req_o && !$past(pg_wr_i) |-> page_o == step_exp); // R6
  AST_ID_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_wr_o |-> id_idx_o <= IDX_W'(2)); // R7
  AST_ID_ORDER_0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_wr_o && id_idx_o == '0 |=> id_wr_o && id_idx_o == IDX_W'(1)); // R7
  AST_ID_ORDER_1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_wr_o && id_idx_o == IDX_W'(1) |=> id_wr_o && id_idx_o == IDX_W'(2)); // R11
  AST_ONE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reset_req_o, load_req_o})); // R8
endmodule

bind boot_cmd_seq boot_cmd_seq_chk #(
  .PAGE_W     (PAGE_W),
  .PAGE_WRAP_W(PAGE_WRAP_W),
  .PAGE_STEP  (PAGE_STEP),
  .IDX_W      (IDX_W)
) u_chk (.*);

// File: tb/boot_cmd_seq_tb.sv
`timescale 1ns/1ps
module boot_cmd_seq_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        pg_wr_i = 1'b0;
  logic [15:0] pg_data_i = '0;
  logic [7:0]  mfr_id_i = 8'hEC;
  logic [7:0]  dev_id_i = 8'h40;
  logic [7:0]  wp_stat_i = 8'h02;
  logic        reset_req_o, load_req_o, id_wr_o;
  logic [15:0] load_page_o, page_o, id_data_o;
  logic [1:0]  id_idx_o;

  always #5 clk = ~clk;

  boot_cmd_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .pg_wr_i(pg_wr_i), .pg_data_i(pg_data_i),
    .mfr_id_i(mfr_id_i), .dev_id_i(dev_id_i), .wp_stat_i(wp_stat_i),
    .reset_req_o(reset_req_o), .load_req_o(load_req_o), .load_page_o(load_page_o),
    .page_o(page_o), .id_wr_o(id_wr_o), .id_idx_o(id_idx_o), .id_data_o(id_data_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int ecnt = 0;
  logic [31:0] exp_q[$];

  // bench model
  bit          m_pend = 0;
  logic [15:0] m_page = '0;
  int          id_s = -100;

  always @(posedge clk) ecnt <= ecnt + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // item encoding: [31:24] kind (1 reset, 2 load, 3 id), low bits payload
  function automatic logic [31:0] item(input int kind, input logic [23:0] pay);
    return {8'(kind), pay};
  endfunction

  task automatic sb_pop(input logic [31:0] got, input string tag);
    if (exp_q.size() == 0) chk(1'b0, {tag, " unexpected strobe"}, got, 32'h0);
    else begin
      logic [31:0] e;
      e = exp_q.pop_front();
      chk(got == e, {tag, " scoreboard"}, got, e);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (reset_req_o) sb_pop(item(1, 24'h0), "R2");
      if (load_req_o)  sb_pop(item(2, {8'h00, load_page_o}), "R5");
      if (id_wr_o)     sb_pop(item(3, {6'h0, id_idx_o, id_data_o}), "R7");
    end
  end

  function automatic bit in_win(input logic [15:0] a);
    return (a <= 16'h01FF) || (a >= 16'h8000 && a <= 16'h800F);
  endfunction

  // driver: one write in the next cycle, expected strobes pushed from the model
  task automatic wr(input logic [15:0] a, input logic [15:0] d,
                    input bit pw = 0, input logic [15:0] pv = '0);
    int n;
    n = ecnt + 1;
    if (in_win(a)) begin
      if (m_pend) begin
        m_pend = 0;
        if (d == 16'h0000) begin
          exp_q.push_back(item(2, {8'h00, m_page}));
          m_page = (m_page + 16'd4) & 16'h00FF;
        end
      end else if (d == 16'h00F0) begin
        exp_q.push_back(item(1, 24'h0));
        m_page = '0;
      end else if (d == 16'h00E0) begin
        m_pend = 1;
      end else if (d == 16'h0090) begin
        if (n >= id_s + 3) begin
          exp_q.push_back(item(3, {6'h0, 2'd0, 8'h00, mfr_id_i}));
          exp_q.push_back(item(3, {6'h0, 2'd1, 8'h00, dev_id_i}));
          exp_q.push_back(item(3, {6'h0, 2'd2, 8'h00, wp_stat_i}));
          id_s = n;
        end
      end
    end
    if (pw) m_page = pv;
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    pg_wr_i = pw; pg_data_i = pv;
    @(negedge clk);
    wr_en_i = 1'b0; pg_wr_i = 1'b0;
  endtask

  task automatic pgw(input logic [15:0] v);
    m_page = v;
    pg_wr_i = 1'b1; pg_data_i = v;
    @(negedge clk);
    pg_wr_i = 1'b0;
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(!reset_req_o && !load_req_o && !id_wr_o, "R9 strobes after reset", {reset_req_o, load_req_o, id_wr_o}, 0);
    chk(page_o == 16'h0, "R9 page after reset", page_o, 0);

    // R10 direct page write
    pgw(16'h1234);
    chk(page_o == 16'h1234, "R10 page write", page_o, 16'h1234);

    // R3 / R5 / R6 load with step
    wr(16'h0010, 16'h00E0);
    chk(!load_req_o && !reset_req_o, "R3 arm gives no strobe", {load_req_o, reset_req_o}, 0);
    idle(1);
    wr(16'h0010, 16'h0000);
    chk(load_req_o == 1'b1, "R5 load strobe", load_req_o, 1);
    chk(load_page_o == 16'h1234, "R5 load page", load_page_o, 16'h1234);
    chk(page_o == 16'h0038, "R6 step and mask", page_o, 16'h0038);
    idle(1);
    chk(load_req_o == 1'b0, "R5 single-cycle load", load_req_o, 0);

    // R6 wrap, R1 upper window edges
    pgw(16'h00FE);
    wr(16'h8000, 16'h00E0);
    wr(16'h800F, 16'h0000);
    chk(page_o == 16'h0002, "R6 wrap", page_o, 16'h0002);
    idle(2);

    // R4 non-zero second write disarms without action
    wr(16'h0001, 16'h00E0);
    wr(16'h0001, 16'h00F0);
    chk(!reset_req_o && page_o == m_page, "R4 armed reset ignored", page_o, m_page);
    wr(16'h0001, 16'h0000);
    chk(!load_req_o && page_o == m_page, "R4 disarmed zero no load", page_o, m_page);
    idle(2);

    // R1 outside the window
    wr(16'h0200, 16'h00F0);
    wr(16'h8010, 16'h00F0);
    wr(16'h7FFF, 16'h00E0);
    wr(16'h01FF, 16'h0000);
    chk(!load_req_o && !reset_req_o && page_o == m_page, "R1 outside writes ignored", page_o, m_page);
    wr(16'h01FF, 16'h00E0);
    wr(16'h0200, 16'h0000);
    chk(!load_req_o, "R1 outside write keeps armed", load_req_o, 0);
    wr(16'h0000, 16'h0000);
    chk(load_req_o == 1'b1, "R1 armed survives outside write", load_req_o, 1);
    idle(2);

    // R2 warm reset
    pgw(16'h0044);
    wr(16'h01FF, 16'h00F0);
    chk(reset_req_o == 1'b1, "R2 reset strobe", reset_req_o, 1);
    chk(page_o == 16'h0000, "R2 page cleared", page_o, 0);
    idle(1);
    chk(reset_req_o == 1'b0, "R2 single-cycle reset", reset_req_o, 0);

    // R8 other values
    pgw(16'h0020);
    wr(16'h0005, 16'h1234);
    wr(16'h0005, 16'h00F1);
    wr(16'h0005, 16'h0091);
    wr(16'h0005, 16'h0000);
    chk(!load_req_o && !reset_req_o && !id_wr_o && page_o == 16'h0020, "R8 no action", page_o, 16'h0020);
    idle(2);

    // R7 identification sequence
    wr(16'h8005, 16'h0090);
    chk(id_wr_o && id_idx_o == 2'd0 && id_data_o == 16'h00EC, "R7 loc0", {id_wr_o, id_idx_o, id_data_o}, {1'b1, 2'd0, 16'h00EC});
    idle(1);
    chk(id_wr_o && id_idx_o == 2'd1 && id_data_o == 16'h0040, "R7 loc1", {id_wr_o, id_idx_o, id_data_o}, {1'b1, 2'd1, 16'h0040});
    idle(1);
    chk(id_wr_o && id_idx_o == 2'd2 && id_data_o == 16'h0002, "R7 loc2", {id_wr_o, id_idx_o, id_data_o}, {1'b1, 2'd2, 16'h0002});
    idle(1);
    chk(!id_wr_o, "R7 sequence ends", id_wr_o, 0);
    idle(2);

    // R11 command during running sequence ignored, then restart at last location
    wr(16'h0003, 16'h0090);
    mfr_id_i = 8'h11; dev_id_i = 8'h22; wp_stat_i = 8'h33;
    wr(16'h0003, 16'h0090);
    idle(1);
    wr(16'h0003, 16'h0090);
    idle(5);
    chk(exp_q.size() == 0, "R11 all id strobes seen", exp_q.size(), 0);

    // R10 page write wins over load step
    pgw(16'h0010);
    wr(16'h0002, 16'h00E0);
    wr(16'h0002, 16'h0000, 1'b1, 16'h0555);
    chk(load_page_o == 16'h0010, "R10 load uses old page", load_page_o, 16'h0010);
    chk(page_o == 16'h0555, "R10 write beats step", page_o, 16'h0555);
    idle(2);

    // R9 reset clears armed state
    wr(16'h0002, 16'h00E0);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    m_pend = 0; m_page = '0; id_s = -100;
    chk(page_o == 16'h0 && load_page_o == 16'h0, "R9 reset clears page", page_o, 0);
    wr(16'h0002, 16'h0000);
    chk(!load_req_o, "R9 reset disarms", load_req_o, 1'b0);
    idle(3);

    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule